// File: doc/BRIEF.md
# Set-Associative Cache Tag Engine

This block tracks the tag state of a set-associative cache without holding any data. Each request carries a byte address and an operation (load, store or modify). The engine splits the address into tag, set index and line offset, searches the ways of the selected set, and reports the outcome on single-cycle event outputs: hit, miss, or miss with eviction. On a miss the new tag is installed, so a repeat access to the same line hits. A modify is run as a load lookup followed by a store lookup on the same address, so it reports two outcomes.

The victim is chosen by a run-time policy input. In least-recently-used mode, both hits and fills refresh the order. In first-in-first-out mode, only fills change the order. An empty way is always filled before a valid line is displaced, and the lowest-numbered empty way is used first. Three saturating counters accumulate hits, misses and evictions. A synchronous clear empties every set, zeroes the counters and restores the initial replacement order. The number of sets, ways and line bytes are parameters, and each must be a power of two.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the request's last lookup has finished, so the requester must hold its next request until `req_ready` returns high. There is no result back-pressure: event outputs and `done` are pulses that the consumer must sample when they occur.

Top module: `cache_tag_engine`

## Requirements
- R1: The line offset is the low log2(LINE_BYTES) address bits. The set index is the next log2(SETS) bits, and the tag is all remaining upper bits. Two addresses in the same line hit each other. Lines in different sets never displace one another.
- R2: A lookup that finds a valid way in the indexed set holding the request tag raises `ev_hit`. Any other lookup raises `ev_miss` and installs the tag, so an immediate repeat of the same address hits.
- R3: `ev_evict` is raised together with `ev_miss` only when every way of the set is already valid. A miss into a set with an empty way raises `ev_miss` alone.
- R4: With `repl_fifo` = 0 (LRU), the displaced line is the one whose last hit or fill is oldest.
- R5: With `repl_fifo` = 1 (FIFO), the displaced line is the one filled earliest. Hits do not change the order.
- R6: The `req_op` encoding is 0 = load, 1 = store, 2 = modify, and 3 behaves as load. A modify gives two outcomes in successive cycles: first the load outcome (miss, with or without eviction, or hit), then a hit for the store.
- R7: Each lookup's outcome is a one-cycle pulse. The first lookup's pulse appears after the second rising edge counted from the acceptance edge. A modify's second pulse appears one cycle later. `done` pulses in the same cycle as the request's final outcome, and never otherwise.
- R8: `req_ready` is high whenever the engine is idle. It is low from the acceptance edge until the final outcome is presented, and it is high again in the cycle that carries `done`.
- R9: `hit_count`, `miss_count` and `evict_count` each add one per matching pulse and saturate at 2^CNT_W-1.
- R10: While `clear` is high on a rising edge, all lines become invalid, the counters go to zero, any request in progress is dropped, and no outcome is pulsed. An address that was resident before the clear then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush of lines, order and counters |
| repl_fifo | input | 1 | Replacement policy: 0 LRU, 1 FIFO |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request |
| req_op | input | 2 | Operation: 0 load, 1 store, 2 modify, 3 load |
| req_addr | input | ADDR_W | Byte address |
| ev_hit | output | 1 | Hit outcome pulse |
| ev_miss | output | 1 | Miss outcome pulse |
| ev_evict | output | 1 | Eviction pulse, together with a miss |
| done | output | 1 | Final outcome of the request |
| hit_count | output | CNT_W | Saturating hit total |
| miss_count | output | CNT_W | Saturating miss total |
| evict_count | output | CNT_W | Saturating eviction total |

## Verification
The properties assume that `clear` and `rst_n` are the only ways to abandon a request. They also assume that `repl_fifo` changes only while the engine is idle, so that one lookup sees one policy. The directed tasks hold to both assumptions: they change the policy and pulse `clear` only between requests, when `req_ready` is high. Each task drops `req_valid` right after acceptance, so no request is presented while the engine is busy.

// File: rtl/cte_pkg.sv
package cte_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_MODIFY = 2'd2,
    OP_ALT    = 2'd3
  } op_e;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_LOOK = 1'b1
  } eng_state_e;
endpackage

// File: rtl/cte_sat_cnt.sv
module cte_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count <= '0;
    else if (clr)                 count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/cte_way_match.sv
module cte_way_match #(
  parameter int WAYS   = 2,
  parameter int TAG_W  = 12,
  parameter int WIDX_W = 1
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic                       hit,
  output logic [WIDX_W-1:0]          hit_way,
  output logic                       any_free,
  output logic [WIDX_W-1:0]          free_way
);
  logic [WAYS-1:0] match_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_vec[g] = row_valid[g] && (row_tag[g] == probe_tag);
  end

  always_comb begin
    hit      = |match_vec;
    any_free = ~&row_valid;
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w])  hit_way  = WIDX_W'(w);
      if (!row_valid[w]) free_way = WIDX_W'(w);
    end
  end
endmodule

// File: rtl/cte_age_ctrl.sv
module cte_age_ctrl #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int IDX_W  = 2,
  parameter int WIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  set_sel,
  input  logic [WIDX_W-1:0] upd_way,
  output logic [WIDX_W-1:0] victim_way
);
  localparam logic [WIDX_W-1:0] OLDEST = WIDX_W'(WAYS - 1);

  // age 0 is the youngest; each set always holds a permutation of 0..WAYS-1
  logic [SETS-1:0][WAYS-1:0][WIDX_W-1:0] age_q;
  logic [WAYS-1:0][WIDX_W-1:0]           row_age;

  assign row_age = age_q[set_sel];

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (row_age[w] == OLDEST) victim_way = WIDX_W'(w);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          age_q[s][w] <= WIDX_W'(w);
        else if (clear)
          age_q[s][w] <= WIDX_W'(w);
        else if (upd_en && set_sel == IDX_W'(s)) begin
          if (upd_way == WIDX_W'(w))
            age_q[s][w] <= '0;
          else if (age_q[s][w] < age_q[s][upd_way])
            age_q[s][w] <= age_q[s][w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cache_tag_engine.sv
module cache_tag_engine
  import cte_pkg::*;
#(
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 4,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              repl_fifo,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              ev_hit,
  output logic              ev_miss,
  output logic              ev_evict,
  output logic              done,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WIDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  eng_state_e                           state_q;
  logic [ADDR_W-1:0]                    addr_q;
  logic                                 two_pass_q;
  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;

  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              hit, any_free;
  logic [WIDX_W-1:0] hit_way, free_way, victim_way, fill_way, touch_way;
  logic              look_act, age_upd;

  assign set_idx   = addr_q[OFF_W +: IDX_W];
  assign look_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign req_ready = (state_q == ENG_IDLE);
  assign look_act  = (state_q == ENG_LOOK) && !clear;

  cte_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WIDX_W(WIDX_W)) u_match (
    .row_valid (valid_q[set_idx]),
    .row_tag   (tag_q[set_idx]),
    .probe_tag (look_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .any_free  (any_free),
    .free_way  (free_way)
  );

  assign fill_way  = any_free ? free_way : victim_way;
  assign touch_way = hit ? hit_way : fill_way;
  // FIFO order moves on fills only; LRU order moves on every lookup
  assign age_upd   = look_act && (!hit || !repl_fifo);

  cte_age_ctrl #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WIDX_W(WIDX_W)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .upd_en     (age_upd),
    .set_sel    (set_idx),
    .upd_way    (touch_way),
    .victim_way (victim_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ENG_IDLE;
      addr_q     <= '0;
      two_pass_q <= 1'b0;
      valid_q    <= '0;
      tag_q      <= '0;
      ev_hit     <= 1'b0;
      ev_miss    <= 1'b0;
      ev_evict   <= 1'b0;
      done       <= 1'b0;
    end else if (clear) begin
      state_q    <= ENG_IDLE;
      two_pass_q <= 1'b0;
      valid_q    <= '0;
      ev_hit     <= 1'b0;
      ev_miss    <= 1'b0;
      ev_evict   <= 1'b0;
      done       <= 1'b0;
    end else begin
      ev_hit   <= 1'b0;
      ev_miss  <= 1'b0;
      ev_evict <= 1'b0;
      done     <= 1'b0;
      case (state_q)
        ENG_IDLE: begin
          if (req_valid) begin
            addr_q     <= req_addr;
            two_pass_q <= (op_e'(req_op) == OP_MODIFY);
            state_q    <= ENG_LOOK;
          end
        end
        ENG_LOOK: begin
          ev_hit   <= hit;
          ev_miss  <= !hit;
          ev_evict <= !hit && !any_free;
          if (!hit) begin
            valid_q[set_idx][fill_way] <= 1'b1;
            tag_q[set_idx][fill_way]   <= look_tag;
          end
          if (two_pass_q) begin
            two_pass_q <= 1'b0;
          end else begin
            done    <= 1'b1;
            state_q <= ENG_IDLE;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  cte_sat_cnt #(.W(CNT_W)) u_cnt_hit (
    .clk(clk), .rst_n(rst_n), .clr(clear), .inc(ev_hit), .count(hit_count));
  cte_sat_cnt #(.W(CNT_W)) u_cnt_miss (
    .clk(clk), .rst_n(rst_n), .clr(clear), .inc(ev_miss), .count(miss_count));
  cte_sat_cnt #(.W(CNT_W)) u_cnt_evict (
    .clk(clk), .rst_n(rst_n), .clr(clear), .inc(ev_evict), .count(evict_count));
endmodule

// File: rtl/cte_checker.sv
module cte_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             req_ready,
  input logic             ev_hit,
  input logic             ev_miss,
  input logic             ev_evict,
  input logic             done,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic [CNT_W-1:0] evict_count
);
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_hit && ev_miss));

  a_r3_evict_is_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict |-> ev_miss);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_with_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ev_hit || ev_miss));

  a_r8_busy_before_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit || ev_miss) |-> !$past(req_ready));

  a_r8_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r9_hits_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count < $past(hit_count)) |-> $past(clear));

  a_r9_miss_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count < $past(miss_count)) |-> $past(clear));

  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> (hit_count == '0 && miss_count == '0 && evict_count == '0
                      && !ev_hit && !ev_miss && !done));
endmodule

bind cache_tag_engine cte_checker #(.CNT_W(CNT_W)) u_cte_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear       (clear),
  .req_ready   (req_ready),
  .ev_hit      (ev_hit),
  .ev_miss     (ev_miss),
  .ev_evict    (ev_evict),
  .done        (done),
  .hit_count   (hit_count),
  .miss_count  (miss_count),
  .evict_count (evict_count)
);

// File: tb/cache_tag_engine_bench.sv
module cache_tag_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 3;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic repl_fifo = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic req_ready, ev_hit, ev_miss, ev_evict, done;
  logic [CW-1:0] hit_count, miss_count, evict_count;

  int total = 0;
  int bad = 0;
  int exp_h = 0, exp_m = 0, exp_e = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_engine #(.SETS(4), .WAYS(2), .LINE_BYTES(4), .ADDR_W(16), .CNT_W(CW)) u_cache_tag_engine (
    .clk(clk), .rst_n(rst_n), .clear(clear), .repl_fifo(repl_fifo),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_evict(ev_evict), .done(done),
    .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count));

  // R1 layout: offset [1:0], set index [3:2], tag [15:4]
  function automatic logic [15:0] adr(input int tag, input int idx, input int off);
    return {tag[11:0], idx[1:0], off[1:0]};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic tally(input int h, input int m, input int e);
    exp_h = sat(exp_h + h); exp_m = sat(exp_m + m); exp_e = sat(exp_e + e);
  endtask

  task automatic check_counts(input string req);
    chk(req, "hit_count", hit_count, exp_h);
    chk(req, "miss_count", miss_count, exp_m);
    chk(req, "evict_count", evict_count, exp_e);
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] a);
    @(negedge clk);
    chk("R8", "ready_idle", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "ready_busy", req_ready, 0);
    chk("R7", "no_early_event", ev_hit | ev_miss, 0);
  endtask

  // single lookup: load/store; outcome h (1 hit) else miss with e
  task automatic access(input logic [1:0] op, input logic [15:0] a,
                        input int h, input int e, input string req);
    send(op, a);
    @(negedge clk);
    chk(req, "hit", ev_hit, h);
    chk(req, "miss", ev_miss, 1 - h);
    chk(req, "evict", ev_evict, e);
    chk("R7", "done", done, 1);
    chk("R8", "ready_at_done", req_ready, 1);
    tally(h, 1 - h, e);
    @(negedge clk);
    chk("R7", "pulse_ends", ev_hit | ev_miss | done, 0);
  endtask

  task automatic modify(input logic [15:0] a, input int h1, input int e1, input string req);
    send(2'd2, a);
    @(negedge clk);
    chk(req, "first_hit", ev_hit, h1);
    chk(req, "first_miss", ev_miss, 1 - h1);
    chk(req, "first_evict", ev_evict, e1);
    chk("R7", "no_done_first", done, 0);
    chk("R8", "busy_between", req_ready, 0);
    @(negedge clk);
    chk("R6", "second_hit", ev_hit, 1);
    chk("R6", "second_evict", ev_evict, 0);
    chk("R7", "done_second", done, 1);
    tally(h1 + 1, 1 - h1, e1);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    exp_h = 0; exp_m = 0; exp_e = 0;
    check_counts("R10");
  endtask

  task automatic t_reset();
    chk("R8", "reset_ready", req_ready, 1);
    chk("R9", "reset_hits", hit_count, 0);
    chk("R7", "reset_events", ev_hit | ev_miss | ev_evict | done, 0);
  endtask

  task automatic t_lru_basic();
    repl_fifo = 1'b0;
    access(2'd0, adr(1,0,0), 0, 0, "R2");
    access(2'd0, adr(1,0,3), 1, 0, "R1");
    access(2'd1, adr(2,0,1), 0, 0, "R3");
    access(2'd3, adr(3,0,0), 0, 1, "R4");
    access(2'd0, adr(2,0,0), 1, 0, "R4");
    access(2'd0, adr(1,0,0), 0, 1, "R4");
    access(2'd0, adr(3,0,0), 0, 1, "R4");
    check_counts("R9");
  endtask

  task automatic t_fifo();
    do_clear();
    @(negedge clk); repl_fifo = 1'b1;
    access(2'd0, adr(1,1,0), 0, 0, "R5");
    access(2'd0, adr(2,1,0), 0, 0, "R5");
    access(2'd0, adr(1,1,0), 1, 0, "R5");
    access(2'd0, adr(3,1,0), 0, 1, "R5");
    access(2'd0, adr(2,1,0), 1, 0, "R5");
    access(2'd0, adr(1,1,0), 0, 1, "R5");
    access(2'd0, adr(3,1,0), 1, 0, "R5");
    check_counts("R9");
  endtask

  task automatic t_lru_contrast();
    do_clear();
    @(negedge clk); repl_fifo = 1'b0;
    access(2'd0, adr(1,1,0), 0, 0, "R4");
    access(2'd0, adr(2,1,0), 0, 0, "R4");
    access(2'd0, adr(1,1,0), 1, 0, "R4");
    access(2'd0, adr(3,1,0), 0, 1, "R4");
    access(2'd0, adr(1,1,0), 1, 0, "R4");
    access(2'd0, adr(2,1,0), 0, 1, "R4");
  endtask

  task automatic t_modify();
    do_clear();
    modify(adr(5,2,0), 0, 0, "R6");
    modify(adr(6,2,2), 0, 0, "R6");
    modify(adr(7,2,1), 0, 1, "R6");
    modify(adr(7,2,3), 1, 0, "R6");
    access(2'd0, adr(6,2,0), 1, 0, "R6");
    access(2'd0, adr(5,3,0), 0, 0, "R1");
    access(2'd0, adr(6,2,0), 1, 0, "R1");
    check_counts("R9");
  endtask

  task automatic t_saturate();
    do_clear();
    access(2'd0, adr(9,0,0), 0, 0, "R9");
    for (int i = 0; i < 9; i++) access(2'd0, adr(9,0,i % 4), 1, 0, "R9");
    chk("R9", "hit_saturated", hit_count, CMAX);
    check_counts("R9");
  endtask

  task automatic t_clear();
    do_clear();
    access(2'd0, adr(9,0,0), 0, 0, "R10");
    check_counts("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lru_basic();
    t_fifo();
    t_lru_contrast();
    t_modify();
    t_saturate();
    t_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule